// File: doc/BRIEF.md
# Input Data Timing Margin Monitor

This block watches a parallel input data bus that a downstream stage latches on the edge of a data clock, and reports when a data transition lands too close to that latching edge. Time is handled digitally. The block runs on a fast oversampling clock, and one cycle of that clock stands for one step of the data clock delay line. A free-running phase counter of 32 steps places the latching edge at the phase chosen by a 5-bit delay setting. Changing the setting moves only the edge. The data path and its sampling are not affected.

A 4-bit guard window, counted in the same steps, sets how near a transition may come to the edge before it counts as a violation. A side select picks what is checked. In setup mode the block checks transitions that occur before the edge. In hold mode it checks transitions that occur after the edge. A violation sets a sticky status bit, which software reads back and clears with a write-one strobe. The status bit and an external sync interrupt are combined onto one active-low interrupt pin.

A typical use is to sweep the delay setting at a fixed window. The edge is then placed where the status bit stays clear, with a known margin.

Top module: `tmm_margin_mon`

## Requirements
- R1: After reset the phase counter starts at 0 and advances by one each clock, modulo 32. `dclk_edge` is high in exactly those cycles where the phase equals `dclk_dly`. Changing `dclk_dly` moves the edge and leaves the transition detection unchanged.
- R2: A transition is a cycle in which `din` differs from its value in the previous cycle. The reference value after reset is all zeros. With `side_sel`=0 (setup), an edge cycle counts as a hit when the most recent transition occurred d cycles earlier, with 0 <= d <= `margin_win`. A transition in the edge cycle itself has d=0.
- R3: With `side_sel`=1 (hold), a transition cycle counts as a hit when the most recent edge occurred d cycles earlier, with 0 <= d <= `margin_win`.
- R4: A distance of `margin_win`+1 is not a hit.
- R5: `margin_win`=0 disables detection.
- R6: `auto_cal`=1 disables detection. The margin check runs only when this bit is 0.
- R7: `irq_en`=0 prevents the status bit from being set.
- R8: A hit sets `dly_status` on the next clock. The bit stays set until a cycle with `irq_clr`=1 clears it on the following clock. A hit in the same cycle as the clear wins.
- R9: `irq_n` is low exactly when `dly_status` or `sync_irq` is high. It follows both without a clock delay.
- R10: During and right after reset, `dly_status` is 0 and `irq_n` follows only `sync_irq`.
- R11: In setup mode, transitions that occur after an edge are ignored. In hold mode, transitions that occur before an edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock, one delay step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | DW | Parallel input data bus |
| dclk_dly | input | 5 | Latching edge phase (delay setting) |
| margin_win | input | 4 | Guard window in delay steps; 0 disables |
| auto_cal | input | 1 | 0 = manual margin check active, 1 = check off |
| irq_en | input | 1 | Enables setting of the status bit |
| side_sel | input | 1 | 0 = setup side, 1 = hold side |
| sync_irq | input | 1 | Second interrupt source, active high |
| irq_clr | input | 1 | Write-one-to-clear strobe for the status bit |
| dclk_edge | output | 1 | High in the latching edge cycle |
| dly_status | output | 1 | Sticky data-delay interrupt status |
| irq_n | output | 1 | Combined active-low interrupt pin |

## Verification
On every cycle the assertions check the following: the edge recurs with the fixed 32-cycle spacing while the delay setting is held, the status bit stays set until it is cleared, the status bit never rises after a cycle in which the check was disabled by mode, enable or a zero window, and the pin agrees with its two sources. Some behaviours need the bench's scenarios and its reference model. These are the exact distance at which a transition becomes a hit on each side, the window boundary at `margin_win`+1, transitions on the unchecked side being ignored, and a hit taking priority over a clear in the same cycle.

// File: rtl/tmm_pkg.sv
// Shared widths and types of the timing margin monitor.
// Assumes one fast clock cycle equals one delay step.
package tmm_pkg;
    localparam int DLY_W  = 5;               // delay setting width
    localparam int WIN_W  = 4;               // guard window width
    localparam int DIST_W = DLY_W;           // distance tracker width
    localparam int PERIOD = 1 << DLY_W;      // steps per data clock period

    typedef enum logic {
        SIDE_SETUP = 1'b0,
        SIDE_HOLD  = 1'b1
    } side_e;

    typedef struct packed {
        logic setup_hit;
        logic hold_hit;
    } hit_t;
endpackage

// File: rtl/tmm_phase_gen.sv
// Phase generator: a free-running counter over one data clock period.
// Flags the cycle where the phase equals the delay setting (the latching edge).
// Assumes the period is a power of two, so the counter wraps naturally.
module tmm_phase_gen #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] dly,
    output logic             edge_o
);
    logic [DLY_W-1:0] phase_q;

    // Advance the phase by one step each clock, restart at zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Edge strobe: the delay setting picks which phase hosts the edge.
    always_comb begin
        edge_o = (phase_q == dly);
    end
endmodule

// File: rtl/tmm_trans_det.sv
// Transition detector: compares the bus with its value one cycle earlier.
// Assumes the reference value after reset is all zeros.
module tmm_trans_det #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic          trans_o
);
    logic [DW-1:0] din_q;

    // Hold the previous bus value as the comparison reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_q <= '0;
        end else begin
            din_q <= din;
        end
    end

    // Any bit that differs from last cycle marks a transition.
    always_comb begin
        trans_o = |(din ^ din_q);
    end
endmodule

// File: rtl/tmm_dist_track.sv
// Distance tracker: reports how many cycles ago an event last occurred.
// Reports 0 in the event cycle itself. The count saturates at its maximum,
// which also stands for "no event seen yet". Assumes the window stays below
// that maximum.
module tmm_dist_track #(
    parameter int DIST_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    output logic [DIST_W-1:0] dist_o
);
    localparam logic [DIST_W-1:0] DIST_MAX = {DIST_W{1'b1}};

    logic [DIST_W-1:0] cnt_q;

    // Restart the count after an event, otherwise count up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= DIST_MAX;
        end else if (evt) begin
            cnt_q <= {{(DIST_W-1){1'b0}}, 1'b1};
        end else if (cnt_q != DIST_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The current cycle's event overrides the stored distance.
    always_comb begin
        dist_o = evt ? '0 : cnt_q;
    end
endmodule

// File: rtl/tmm_win_cmp.sv
// Window comparator: decides whether the current cycle is a margin hit.
// Setup side: at an edge, the last transition must lie within the window.
// Hold side: at a transition, the last edge must lie within the window.
// Assumes both distances already include the current cycle as 0.
module tmm_win_cmp
    import tmm_pkg::*;
#(
    parameter int DIST_W = 5,
    parameter int WIN_W  = 4
) (
    input  logic              check_on,
    input  side_e             side,
    input  logic [WIN_W-1:0]  win,
    input  logic              edge_now,
    input  logic              trans_now,
    input  logic [DIST_W-1:0] dist_trans,
    input  logic [DIST_W-1:0] dist_edge,
    output logic              hit_o
);
    localparam int CMP_W = (DIST_W > WIN_W) ? DIST_W : WIN_W;

    logic [CMP_W-1:0] win_x;
    logic [CMP_W-1:0] dt_x;
    logic [CMP_W-1:0] de_x;
    hit_t             hits;

    // Widen the operands to a common width for the comparison.
    always_comb begin
        win_x = CMP_W'(win);
        dt_x  = CMP_W'(dist_trans);
        de_x  = CMP_W'(dist_edge);
    end

    // Evaluate each side, then keep only the selected one.
    always_comb begin
        hits.setup_hit = edge_now  && (dt_x <= win_x);
        hits.hold_hit  = trans_now && (de_x <= win_x);
        hit_o = check_on && (win != '0) &&
                ((side == SIDE_SETUP) ? hits.setup_hit : hits.hold_hit);
    end
endmodule

// File: rtl/tmm_margin_mon.sv
// Top of the timing margin monitor. It ties together the phase generator,
// the transition detector, two distance trackers and the window comparator.
// It holds the sticky status bit and drives the shared active-low pin.
// Assumes a single fast clock and a synchronous active-low reset.
module tmm_margin_mon
    import tmm_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    din,
    input  logic [DLY_W-1:0] dclk_dly,
    input  logic [WIN_W-1:0] margin_win,
    input  logic             auto_cal,
    input  logic             irq_en,
    input  logic             side_sel,
    input  logic             sync_irq,
    input  logic             irq_clr,
    output logic             dclk_edge,
    output logic             dly_status,
    output logic             irq_n
);
    localparam int NTRK = 2;                 // 0: edge tracker, 1: transition tracker

    logic              edge_now;
    logic              trans_now;
    logic [NTRK-1:0]   trk_evt;
    logic [DIST_W-1:0] trk_dist [NTRK];
    logic              check_on;
    logic              hit;
    logic              status_q;

    tmm_phase_gen #(.DLY_W(DLY_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .dly    (dclk_dly),
        .edge_o (edge_now)
    );

    tmm_trans_det #(.DW(DW)) u_trans (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .trans_o (trans_now)
    );

    // Route the two event sources to their trackers.
    always_comb begin
        trk_evt = {trans_now, edge_now};
    end

    for (genvar g = 0; g < NTRK; g++) begin : g_trk
        tmm_dist_track #(.DIST_W(DIST_W)) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (trk_evt[g]),
            .dist_o (trk_dist[g])
        );
    end

    // Detection runs in manual mode with the enable set.
    always_comb begin
        check_on = !auto_cal && irq_en;
    end

    tmm_win_cmp #(.DIST_W(DIST_W), .WIN_W(WIN_W)) u_cmp (
        .check_on   (check_on),
        .side       (side_e'(side_sel)),
        .win        (margin_win),
        .edge_now   (edge_now),
        .trans_now  (trans_now),
        .dist_trans (trk_dist[1]),
        .dist_edge  (trk_dist[0]),
        .hit_o      (hit)
    );

    // Sticky status: a hit sets it and wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else begin
            status_q <= hit | (status_q & ~irq_clr);
        end
    end

    // Outputs: edge strobe, status readback, combined active-low pin.
    always_comb begin
        dclk_edge  = edge_now;
        dly_status = status_q;
        irq_n      = ~(status_q | sync_irq);
    end
endmodule

// File: rtl/tmm_margin_mon_chk.sv
// Checker for the timing margin monitor, bound to the top module.
// Watches the ports only. A local counter measures the spacing between edges.
module tmm_margin_mon_chk
    import tmm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [DLY_W-1:0] dclk_dly,
    input logic [WIN_W-1:0] margin_win,
    input logic             auto_cal,
    input logic             irq_en,
    input logic             sync_irq,
    input logic             irq_clr,
    input logic             dclk_edge,
    input logic             dly_status,
    input logic             irq_n
);
    logic [DLY_W:0] gap_q;
    logic           armed_q;

    // Count cycles since the last edge. Arm only while the delay is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            if (dclk_edge) begin
                gap_q   <= '0;
                armed_q <= 1'b1;
            end else if (gap_q != {(DLY_W+1){1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
            if (dclk_dly != $past(dclk_dly)) armed_q <= 1'b0;
        end
    end

    AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_edge && armed_q && $stable(dclk_dly)) |-> (gap_q == (DLY_W+1)'(PERIOD - 1))); // R1
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_edge && $stable(dclk_dly)) |=> (!dclk_edge || $changed(dclk_dly))); // R1
    AST_NO_SET_WIN0: assert property (@(posedge clk) disable iff (!rst_n)
        (margin_win == '0 && !dly_status) |=> !dly_status); // R5
    AST_NO_SET_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cal && !dly_status) |=> !dly_status); // R6
    AST_NO_SET_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en && !dly_status) |=> !dly_status); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_status && !irq_clr) |=> dly_status); // R8
    AST_PIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> !irq_n); // R9
    AST_PIN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (dly_status || sync_irq)); // R9
endmodule

bind tmm_margin_mon tmm_margin_mon_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dclk_dly   (dclk_dly),
    .margin_win (margin_win),
    .auto_cal   (auto_cal),
    .irq_en     (irq_en),
    .sync_irq   (sync_irq),
    .irq_clr    (irq_clr),
    .dclk_edge  (dclk_edge),
    .dly_status (dly_status),
    .irq_n      (irq_n)
);

// File: tb/tmm_margin_mon_bench.sv
// Bench for the timing margin monitor. A behavioural model working in absolute
// cycle times is compared with the outputs on every cycle, and scenario checks
// are added on top.
module tmm_margin_mon_bench;
    localparam int CLK_P = 10;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [4:0]    dclk_dly = 5'd5;
    logic [3:0]    margin_win = 4'd0;
    logic          auto_cal = 1'b0;
    logic          irq_en = 1'b0;
    logic          side_sel = 1'b0;
    logic          sync_irq = 1'b0;
    logic          irq_clr = 1'b0;
    logic          dclk_edge, dly_status, irq_n;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    run_cmp = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R10";

    // reference model state
    int            m_t = 0;
    int            m_ph = 0;
    int            m_last_edge = -1000;
    int            m_last_trans = -1000;
    logic [DW-1:0] m_prev = '0;
    bit            m_status = 1'b0;
    int            edge_cnt = 0;

    tmm_margin_mon #(.DW(DW)) u_tmm_margin_mon (
        .clk(clk), .rst_n(rst_n), .din(din), .dclk_dly(dclk_dly),
        .margin_win(margin_win), .auto_cal(auto_cal), .irq_en(irq_en),
        .side_sel(side_sel), .sync_irq(sync_irq), .irq_clr(irq_clr),
        .dclk_edge(dclk_edge), .dly_status(dly_status), .irq_n(irq_n)
    );

    always #(CLK_P/2) clk = ~clk;

    // Model update on each rising edge, from the inputs driven one cycle before.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_t = 0; m_ph = 0; m_last_edge = -1000; m_last_trans = -1000;
            m_prev = '0; m_status = 1'b0;
        end else begin
            bit tr, ed, hit;
            int dt, de;
            tr = (din != m_prev);
            ed = (m_ph == int'(dclk_dly));
            dt = m_t - (tr ? m_t : m_last_trans);
            de = m_t - (ed ? m_t : m_last_edge);
            hit = 1'b0;
            if (!auto_cal && irq_en && margin_win != 0) begin
                if (!side_sel) hit = ed && (dt <= int'(margin_win));
                else           hit = tr && (de <= int'(margin_win));
            end
            m_status = hit || (m_status && !irq_clr);
            if (tr) m_last_trans = m_t;
            if (ed) m_last_edge = m_t;
            m_prev = din;
            m_ph = (m_ph + 1) % 32;
            m_t++;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, sampled halfway between rising edges.
    always @(negedge clk) begin
        if (run_cmp && !done) begin
            check(cur_req, int'(dly_status), int'(m_status), "status vs model");
            check(cur_req, int'(irq_n), int'(!(m_status || sync_irq)), "irq_n vs model");
            check(cur_req, int'(dclk_edge), int'(m_ph == int'(dclk_dly)), "edge vs model");
            if (dclk_edge) edge_cnt++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Advance until the next rising edge evaluates the given phase.
    task automatic goto_phase(input int p);
        while (m_ph != ((p % 32 + 32) % 32)) step(1);
    endtask

    task automatic clear_status();
        irq_clr = 1'b1; step(1); irq_clr = 1'b0; step(1);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R10: reset state
        step(3);
        check("R10", int'(dly_status), 0, "status in reset");
        check("R10", int'(irq_n), 1, "pin in reset");
        rst_n = 1'b1;
        run_cmp = 1'b1;
        step(1);
        check("R10", int'(dly_status), 0, "status after reset");

        // R1: edge spacing with delay 5
        cur_req = "R1";
        edge_cnt = 0;
        step(64);
        check("R1", edge_cnt, 2, "edges in 64 cycles");

        // R2: setup side, transition 3 steps before edge, window 3
        cur_req = "R2";
        irq_en = 1'b1; margin_win = 4'd3; side_sel = 1'b0;
        goto_phase(5 - 3); din = din ^ 16'h0001;
        step(6);
        check("R2", int'(dly_status), 1, "setup hit at d=win");
        clear_status();
        // R2: transition in the edge cycle itself
        goto_phase(5); din = din ^ 16'h8000;
        step(2);
        check("R2", int'(dly_status), 1, "setup hit at d=0");
        clear_status();

        // R4: setup side, d = win+1
        cur_req = "R4";
        goto_phase(5 - 4); din = din ^ 16'h0010;
        step(8);
        check("R4", int'(dly_status), 0, "setup d=win+1");

        // R11: setup side ignores a transition just after the edge
        cur_req = "R11";
        goto_phase(5 + 1); din = din ^ 16'h0100;
        step(10);
        check("R11", int'(dly_status), 0, "setup ignores late transition");

        // R3: hold side, transition 3 steps after edge
        cur_req = "R3";
        side_sel = 1'b1;
        goto_phase(5 + 3); din = din ^ 16'h0002;
        step(2);
        check("R3", int'(dly_status), 1, "hold hit at d=win");
        clear_status();
        cur_req = "R4";
        goto_phase(5 + 4); din = din ^ 16'h0004;
        step(2);
        check("R4", int'(dly_status), 0, "hold d=win+1");
        cur_req = "R11";
        goto_phase(5 - 1); din = din ^ 16'h0200;
        step(3);
        check("R11", int'(dly_status), 0, "hold ignores early transition");

        // R5: window zero disables
        cur_req = "R5";
        margin_win = 4'd0;
        goto_phase(5); din = din ^ 16'h0008;
        step(3);
        check("R5", int'(dly_status), 0, "window 0");
        margin_win = 4'd3;

        // R6: automatic mode disables
        cur_req = "R6";
        auto_cal = 1'b1;
        goto_phase(5); din = din ^ 16'h0020;
        step(3);
        check("R6", int'(dly_status), 0, "auto mode");
        auto_cal = 1'b0;

        // R7: enable low
        cur_req = "R7";
        irq_en = 1'b0;
        goto_phase(5 + 1); din = din ^ 16'h0040;
        step(3);
        check("R7", int'(dly_status), 0, "enable off");
        irq_en = 1'b1;

        // R8: stickiness, clear, and hit over clear
        cur_req = "R8";
        goto_phase(5 + 2); din = din ^ 16'h0080;
        step(40);
        check("R8", int'(dly_status), 1, "sticky after 40 cycles");
        check("R9", int'(irq_n), 0, "pin low from status");
        clear_status();
        check("R8", int'(dly_status), 0, "cleared");
        goto_phase(5); din = din ^ 16'h0400; irq_clr = 1'b1;
        step(1); irq_clr = 1'b0;
        check("R8", int'(dly_status), 1, "hit wins over clear");
        clear_status();

        // R9: sync source alone drives the pin
        cur_req = "R9";
        sync_irq = 1'b1; #1;
        check("R9", int'(irq_n), 0, "sync only");
        step(2);
        sync_irq = 1'b0; #1;
        check("R9", int'(irq_n), 1, "both idle");
        step(1);

        // R1: moving the edge to phase 20
        cur_req = "R1";
        dclk_dly = 5'd20;
        goto_phase(20); step(1);
        check("R1", int'(dclk_edge), 0, "edge gone after phase 20");
        side_sel = 1'b0;
        goto_phase(20 - 2); din = din ^ 16'h1000;
        step(4);
        check("R1", int'(dly_status), 1, "setup hit relative to moved edge");
        clear_status();
        step(40);

        finish_run();
    end
endmodule